// File: doc/BRIEF.md
# Inter-Core Send Command Dispatcher

This block takes 64-bit send commands that any core writes into one of three command registers. It turns each command into an action on one target core's register space. An interrupt-send command raises one pending-vector bit on the target through a single-cycle strobe. A mailbox-send command writes one 32-bit word into one of the target's eight mailbox words. A free-offset send writes a 32-bit word at any 16-bit offset of the target.

Both write commands carry a four-bit byte keep mask. When the mask is clear, the new word goes straight out as a write. When any keep bit is set, the block first reads the target word. It then merges the kept old bytes with the new bytes and writes the result back. While one of these write sequences is in progress, the command port is held off, so no other send can slip between the read and the write-back. A command that names a core beyond the configured count is dropped, and an error pulse is raised.

Top module: `ipi_send_dispatch`

## Requirements
- R1: After reset, cmdReady is 1 and regReq, setVecValid and errPulse are 0.
- R2: An accepted command at offset 0x40 whose core ID (bits 25:16) is below NumCores makes setVecValid high for exactly the next cycle. In that cycle tgtId equals the core ID and setVecMask equals 1 shifted left by bits 4:0. The command port stays ready.
- R3: A command at any of the three send offsets whose core ID is NumCores or above causes no request and no vector strobe. It causes errPulse to be high for exactly the next cycle.
- R4: A mailbox send (offset 0x48) addresses target offset 0x20 + 4 × bits 4:2.
- R5: A free-offset send (offset 0x158) addresses the target offset given by bits 15:0.
- R6: A write command whose keep mask (bits 30:27) is zero issues only a write (regWe=1), in the cycle after acceptance. Its data is command bits 63:32.
- R7: With a nonzero keep mask, the block first issues a read (regWe=0) to the same address and takes regRdata when regAck is seen. After one cycle with no request, it writes a word in which byte i comes from the read data if keep bit i (command bit 27+i) is 1, and from command bits 63:32 otherwise.
- R8: A request holds regReq, regWe, regAddr, regWdata and tgtId steady until the cycle in which regAck is 1.
- R9: cmdReady is 0 from the cycle after a write command is accepted until the cycle after its write-back is acknowledged, and is 1 again in that cycle.
- R10: A command at any other offset has no effect: no request, no vector strobe, no error, and the port stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command write present |
| cmdReady | output | 1 | Block can accept a command |
| cmdAddr | input | AddrW | Offset of the written command register |
| cmdData | input | 64 | Command word |
| tgtId | output | IdW | Target core of the current action |
| setVecValid | output | 1 | One-cycle strobe to set a pending vector |
| setVecMask | output | 32 | One-hot vector bit to set |
| errPulse | output | 1 | One-cycle pulse for a nonexistent target |
| regReq | output | 1 | Target register request |
| regWe | output | 1 | 1 = write, 0 = read |
| regAddr | output | 16 | Target register offset |
| regWdata | output | 32 | Write data |
| regRdata | input | 32 | Read data, valid with regAck on a read |
| regAck | input | 1 | Request completes this cycle |

## Verification
The vector strobe and the error pulse are registered. They are therefore due one cycle after the accepting edge, and last one cycle. The first request of a write sequence is also due one cycle after acceptance. After a read is acknowledged, there is one idle merge cycle, and the write appears one cycle after that. The port is ready again in the cycle after the write acknowledge. The bench drives inputs and samples outputs on the falling edge, so each sample falls on the first half of exactly the cycle in which the result is due. The acknowledge delay is varied from 0 to 2 cycles to check that requests hold steady while waiting.

// File: rtl/ipi_dispatch_pkg.sv
package ipi_dispatch_pkg;
  // command register offsets
  localparam int unsigned OffIpiSend  = 'h040;
  localparam int unsigned OffMailSend = 'h048;
  localparam int unsigned OffAnySend  = 'h158;
  // command field positions
  localparam int unsigned IdLsb   = 16;
  localparam int unsigned KeepLsb = 27;
  localparam int unsigned WordLsb = 32;
  localparam int unsigned SlotLsb = 2;
  localparam int unsigned VecW    = 5;
  localparam int unsigned WordW   = 32;
  localparam int unsigned RegOffW = 16;
  localparam int unsigned Bytes   = WordW / 8;
  localparam int unsigned MailBase = 'h20;

  typedef enum logic [1:0] {StIdle, StRead, StMerge, StWrite} state_e;

  typedef struct packed {
    logic load;     // latch a write command
    logic selAny;   // free-offset form
    logic loadVec;  // latch a vector send
    logic capRead;  // capture read data
    logic doMerge;  // build the merged word
  } strobe_t;
endpackage

// File: rtl/ipi_dispatch_ctrl.sv
module ipi_dispatch_ctrl
  import ipi_dispatch_pkg::*;
#(
  parameter int unsigned NumCores = 64,
  parameter int unsigned IdW      = 10,
  parameter int unsigned AddrW    = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [AddrW-1:0] cmdAddr,
  input  logic [IdW-1:0]   cmdId,
  input  logic [Bytes-1:0] cmdKeep,
  input  logic             regAck,
  output logic             cmdReady,
  output logic             regReq,
  output logic             regWe,
  output logic             setVecValid,
  output logic             errPulse,
  output strobe_t          stb
);
  state_e state, stateNext;
  logic accept, isIpi, isMail, isAny, idOk;

  always_comb begin
    accept = cmdValid && (state == StIdle);
    isIpi  = cmdAddr == AddrW'(OffIpiSend);
    isMail = cmdAddr == AddrW'(OffMailSend);
    isAny  = cmdAddr == AddrW'(OffAnySend);
    idOk   = 32'(cmdId) < 32'(NumCores);

    stb.load    = accept && (isMail || isAny) && idOk;
    stb.selAny  = isAny;
    stb.loadVec = accept && isIpi && idOk;
    stb.capRead = (state == StRead) && regAck;
    stb.doMerge = state == StMerge;

    stateNext = state;
    unique case (state)
      StIdle:  if (stb.load) stateNext = (|cmdKeep) ? StRead : StWrite;
      StRead:  if (regAck) stateNext = StMerge;
      StMerge: stateNext = StWrite;
      StWrite: if (regAck) stateNext = StIdle;
      default: stateNext = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= StIdle;
      setVecValid <= 1'b0;
      errPulse    <= 1'b0;
    end else begin
      state       <= stateNext;
      setVecValid <= stb.loadVec;
      errPulse    <= accept && (isIpi || isMail || isAny) && !idOk;
    end
  end

  assign cmdReady = state == StIdle;
  assign regReq   = (state == StRead) || (state == StWrite);
  assign regWe    = state == StWrite;
endmodule

// File: rtl/ipi_dispatch_dp.sv
module ipi_dispatch_dp
  import ipi_dispatch_pkg::*;
#(
  parameter int unsigned IdW = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [IdW-1:0]     cmdId,
  input  logic [Bytes-1:0]   cmdKeep,
  input  logic [WordW-1:0]   cmdWord,
  input  logic [RegOffW-1:0] cmdLow,
  input  logic [WordW-1:0]   regRdata,
  output logic [IdW-1:0]     tgtId,
  output logic [RegOffW-1:0] regAddr,
  output logic [WordW-1:0]   regWdata,
  output logic [WordW-1:0]   setVecMask
);
  logic [Bytes-1:0]   keepReg;
  logic [WordW-1:0]   oldWord, mergedWord;
  logic [RegOffW-1:0] mailAddr;

  assign mailAddr = RegOffW'(MailBase) + {cmdLow[SlotLsb +: 3], 2'b00};

  for (genvar b = 0; b < Bytes; b++) begin : g_merge
    assign mergedWord[8*b +: 8] = keepReg[b] ? oldWord[8*b +: 8] : regWdata[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtId      <= '0;
      regAddr    <= '0;
      regWdata   <= '0;
      keepReg    <= '0;
      oldWord    <= '0;
      setVecMask <= '0;
    end else begin
      if (stb.load || stb.loadVec) tgtId <= cmdId;
      if (stb.load) begin
        regAddr  <= stb.selAny ? cmdLow : mailAddr;
        regWdata <= cmdWord;
        keepReg  <= cmdKeep;
      end
      if (stb.loadVec) setVecMask <= WordW'(1) << cmdLow[VecW-1:0];
      if (stb.capRead) oldWord <= regRdata;
      if (stb.doMerge) regWdata <= mergedWord;
    end
  end
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
  import ipi_dispatch_pkg::*;
#(
  parameter int unsigned NumCores = 64,
  parameter int unsigned IdW      = 10,
  parameter int unsigned AddrW    = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [AddrW-1:0]   cmdAddr,
  input  logic [63:0]        cmdData,
  output logic [IdW-1:0]     tgtId,
  output logic               setVecValid,
  output logic [WordW-1:0]   setVecMask,
  output logic               errPulse,
  output logic               regReq,
  output logic               regWe,
  output logic [RegOffW-1:0] regAddr,
  output logic [WordW-1:0]   regWdata,
  input  logic [WordW-1:0]   regRdata,
  input  logic               regAck
);
  strobe_t stb;
  logic [IdW-1:0]   cmdId;
  logic [Bytes-1:0] cmdKeep;
  logic unusedBits;

  assign cmdId      = cmdData[IdLsb +: IdW];
  assign cmdKeep    = cmdData[KeepLsb +: Bytes];
  assign unusedBits = ^{cmdData[31], cmdData[26]};

  ipi_dispatch_ctrl #(.NumCores(NumCores), .IdW(IdW), .AddrW(AddrW)) u_ctrl (
    .clk, .rstN, .cmdValid, .cmdAddr, .cmdId, .cmdKeep, .regAck,
    .cmdReady, .regReq, .regWe, .setVecValid, .errPulse, .stb
  );

  ipi_dispatch_dp #(.IdW(IdW)) u_dp (
    .clk, .rstN, .stb, .cmdId, .cmdKeep,
    .cmdWord(cmdData[WordLsb +: WordW]),
    .cmdLow(cmdData[RegOffW-1:0]),
    .regRdata, .tgtId, .regAddr, .regWdata, .setVecMask
  );
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int unsigned NumCores = 64,
  parameter int unsigned IdW      = 10
) (
  input logic           clk,
  input logic           rstN,
  input logic           cmdReady,
  input logic           regReq,
  input logic           regWe,
  input logic           regAck,
  input logic [15:0]    regAddr,
  input logic [31:0]    regWdata,
  input logic [IdW-1:0] tgtId,
  input logic           setVecValid,
  input logic [31:0]    setVecMask,
  input logic           errPulse
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regAck |=> regReq && $stable(regWe) && $stable(regAddr)
                          && $stable(regWdata) && $stable(tgtId));
  a_r9_busy: assert property (@(posedge clk) disable iff (!rstN)
    regReq |-> !cmdReady);
  a_r9_ready_after_write: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe && regAck |=> cmdReady);
  a_r7_merge_gap: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regWe && regAck |=> !regReq && !cmdReady);
  a_r7_write_follows: assert property (@(posedge clk) disable iff (!rstN)
    !regReq && !cmdReady |=> regReq && regWe);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    setVecValid |-> $countones(setVecMask) == 1 && 32'(tgtId) < 32'(NumCores));
  a_r3_err_alone: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !setVecValid);
endmodule

bind ipi_send_dispatch ipi_dispatch_chk #(.NumCores(NumCores), .IdW(IdW)) u_chk (.*);

// File: tb/test_ipi_send_dispatch.sv
`timescale 1ns/1ps
module test_ipi_send_dispatch;
  localparam int unsigned NC = 5;
  logic clk = 0, rstN = 0;
  logic cmdValid = 0, regAck = 0;
  logic [8:0] cmdAddr = '0;
  logic [63:0] cmdData = '0;
  logic [31:0] regRdata = '0;
  logic cmdReady, setVecValid, errPulse, regReq, regWe;
  logic [9:0] tgtId;
  logic [31:0] setVecMask, regWdata;
  logic [15:0] regAddr;
  int nChecks = 0, nErr = 0;

  always #2 clk = ~clk;

  ipi_send_dispatch #(.NumCores(NC)) i_ipi_send_dispatch (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mergeExp(input logic [31:0] oldW, input logic [31:0] newW, input logic [3:0] k);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = k[b] ? oldW[8*b +: 8] : newW[8*b +: 8];
    return r;
  endfunction

  task automatic issue(input logic [8:0] a, input logic [63:0] d);
    @(negedge clk);
    chk(cmdReady, "R9 ready before command", 64'(cmdReady), 1);
    cmdAddr = a; cmdData = d; cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic serveReq(input bit we, input logic [15:0] a, input logic [31:0] wd,
                          input logic [9:0] id, input int dly, input logic [31:0] rd);
    chk(regReq && regWe == we, "R6/R7 request kind", {regReq, regWe}, {1'b1, we});
    chk(regAddr == a, "R4/R5 request address", 64'(regAddr), 64'(a));
    chk(tgtId == id, "R4/R5 target id", 64'(tgtId), 64'(id));
    if (we) chk(regWdata == wd, "R6/R7 write data", 64'(regWdata), 64'(wd));
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(regReq && regWe == we && regAddr == a && tgtId == id && !cmdReady && (!we || regWdata == wd),
          "R8 request held / R9 busy", {regReq, regWe, regAddr}, {1'b1, we, a});
    end
    regAck = 1; regRdata = rd;
    @(negedge clk);
    regAck = 0; regRdata = '0;
  endtask

  task automatic writeCmd(input bit any, input logic [15:0] off, input logic [2:0] slot,
                          input logic [9:0] id, input logic [3:0] k, input logic [31:0] w,
                          input logic [31:0] oldW, input int dly);
    logic [63:0] d = '0;
    logic [15:0] a;
    d[63:32] = w; d[30:27] = k; d[25:16] = id;
    if (any) begin d[15:0] = off; a = off; end
    else begin d[4:2] = slot; d[1:0] = 2'(slot); a = 16'h20 + 16'(slot) * 4; end
    issue(any ? 9'h158 : 9'h048, d);
    if (k != 0) begin
      serveReq(0, a, 0, id, dly, oldW);
      chk(!regReq && !cmdReady, "R7 merge cycle idle", {regReq, cmdReady}, 0);
      @(negedge clk);
      serveReq(1, a, mergeExp(oldW, w, k), id, dly, 0);
    end else begin
      serveReq(1, a, w, id, dly, 0);
    end
    chk(cmdReady && !regReq, "R9 ready after write ack", {cmdReady, regReq}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: run hung actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(cmdReady && !regReq && !setVecValid && !errPulse, "R1 reset state",
        {cmdReady, regReq, setVecValid, errPulse}, 4'b1000);

    // R2: every vector number
    for (int v = 0; v < 32; v++) begin
      logic [63:0] d = '0;
      d[4:0] = 5'(v); d[25:16] = 10'(v % NC); d[63:32] = 32'hFFFF_FFFF;
      issue(9'h040, d);
      chk(setVecValid && setVecMask == (32'd1 << v) && tgtId == 10'(v % NC),
          "R2 vector strobe", {setVecValid, setVecMask}, {1'b1, 32'd1 << v});
      chk(!regReq && !errPulse && cmdReady, "R2 no request, stays ready", {regReq, errPulse, cmdReady}, 3'b001);
      @(negedge clk);
      chk(!setVecValid, "R2 single-cycle strobe", 64'(setVecValid), 0);
    end

    // R4, R6, R7: every mailbox slot with every keep mask
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 16; k++)
        writeCmd(0, 0, 3'(s), 10'((s + k) % NC), 4'(k),
                 32'hCAFE_0000 + 32'(k * 37 + s), 32'h1122_3344 * 32'(k + 1), (s + k) % 3);

    // R5: free offsets with every keep mask
    for (int k = 0; k < 16; k++)
      writeCmd(1, 16'h0100 * 16'(k) + 16'(k * 4), 0, 10'(k % NC), 4'(k),
               32'h9876_5432 ^ 32'(k * 4099), 32'h0F0F_A5A5 + 32'(k * 65537), k % 3);

    // R3: nonexistent targets on all three offsets
    for (int t = 0; t < 3; t++) begin
      logic [63:0] d = '0;
      d[25:16] = (t == 0) ? 10'(NC) : 10'd1023;
      d[30:27] = 4'(t * 5);
      issue((t == 0) ? 9'h040 : (t == 1) ? 9'h048 : 9'h158, d);
      chk(errPulse && !setVecValid && !regReq, "R3 error pulse, no action",
          {errPulse, setVecValid, regReq}, 3'b100);
      @(negedge clk);
      chk(!errPulse && cmdReady && !regReq, "R3 single pulse, stays idle",
          {errPulse, cmdReady, regReq}, 3'b010);
    end

    // R10: unused offsets
    for (int u = 0; u < 4; u++) begin
      logic [8:0] a = (u == 0) ? 9'h044 : (u == 1) ? 9'h000 : (u == 2) ? 9'h150 : 9'h04C;
      issue(a, {32'h1234_5678, 32'h0001_0007});
      chk(!setVecValid && !regReq && !errPulse && cmdReady, "R10 ignored offset",
          {setVecValid, regReq, errPulse, cmdReady}, 4'b0001);
      @(negedge clk);
      chk(!setVecValid && !regReq && !errPulse, "R10 still quiet", {setVecValid, regReq, errPulse}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule